// File: doc/BRIEF.md
# UART transmitter with idle fill

This block serialises bytes from a small internal queue onto a single transmit line. Each byte goes out as an 11-bit frame: one start bit, eight data bits sent least significant bit first, a ninth marker bit, and one stop bit. A byte taken from the queue always carries a marker of 1, which tells the far end that the frame holds real payload.

In fill mode the line never goes quiet. Whenever the queue is empty at a frame boundary, the transmitter sends the fixed word 0xAA with its marker at 0. A receiver that accepts only marked frames therefore drops these fill frames without any effort. In plain mode an empty queue stops the transmitter, and the line rests high until a byte arrives.

An optional clear-to-send handshake holds back payload. It does not hold back fill frames. Bit timing comes from a run-time divisor N over 16x oversampling, so one bit lasts 16*(N+1) clock cycles. Software picks N as round(f_clk / (16*baud)) - 1.

Top module: `uart_fill_tx`

## Requirements
- R1: After reset the line `txd` is high, `tx_active` is low and `push_ready` is high.
- R2: A frame is the start bit (0), the eight data bits with the least significant first, the marker bit, and then the stop bit (1). Every bit lasts exactly 16*(`baud_div`+1) clock cycles.
- R3: Bytes taken from the queue leave in the order they were pushed, with marker bit 1.
- R4: In fill mode with an empty queue, the frame sent is data 0xAA with marker 0. Frames follow one another with no idle time between the stop bit and the next start bit.
- R5: A byte pushed while a fill frame is on the line goes out as the very next frame. A frame in progress is never cut short, and `txd` changes only at bit boundaries.
- R6: In plain mode with an empty queue, the transmitter stops. `tx_active` is low and `txd` stays high.
- R7: With `hs_en` high and `cts` low at a frame boundary while data waits, no payload frame starts. Payload resumes only after a rising edge of `cts`. In fill mode, fill frames continue during the wait.
- R8: The queue holds DEPTH bytes. When it is full, `push_ready` is low and a push is ignored.
- R9: With `hs_en` low, the level of `cts` has no effect on payload transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | 16 | Divisor N; one bit lasts 16*(N+1) cycles |
| fill_en | input | 1 | 1: send fill frames when empty; 0: stop when empty |
| hs_en | input | 1 | Enables the clear-to-send handshake |
| cts | input | 1 | Clear-to-send from the far end, active high |
| push_valid | input | 1 | Write strobe into the queue |
| push_data | input | 8 | Byte to queue |
| push_ready | output | 1 | Queue can accept a byte |
| txd | output | 1 | Serial output, high when idle |
| tx_active | output | 1 | A frame is being shifted out |

## Verification
The bench decodes the line with its own mid-bit sampler. It measures the start bit length at a non-zero divisor, so a prescaler that is off by one reload shows up as a wrong cycle count. It pushes a byte in the middle of a fill frame and expects that byte in the next frame. A design that truncated the fill frame, or that sent one more fill first, would fail this check.

It holds `cts` low with data waiting and confirms that the line stays silent. In fill mode it confirms that only unmarked fill frames appear during the wait. It then expects payload right after the rising edge. It also fills the queue while the line is blocked and confirms that a push made while the queue is full never reaches the line.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } uft_state_e;

  localparam int OSR = 16;

endpackage

// File: rtl/uft_fifo.sv
module uft_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [W-1:0]       wdata,
  input  logic               pop,
  output logic [W-1:0]       rdata,
  output logic               empty,
  output logic               full,
  output logic [$clog2(DEPTH):0] level
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q, wp_d, rp_d;
  logic         do_push;

  assign level   = wp_q - rp_q;
  assign empty   = (wp_q == rp_q);
  assign full    = (level == DEPTH[AW:0]);
  assign do_push = push && !full;
  assign rdata   = mem[rp_q[AW-1:0]];

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (do_push) wp_d = wp_q + 1'b1;
    if (pop && !empty) rp_d = rp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q[AW-1:0]] <= wdata;
  end

endmodule

// File: rtl/uft_baud.sv
module uft_baud #(
  parameter int DIV_W = 16,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             bit_done
);
  localparam int SW = $clog2(OSR);

  logic [DIV_W-1:0] pre_q, pre_d;
  logic [SW-1:0]    sub_q, sub_d;
  logic             tick;

  assign tick     = (pre_q == div);
  assign bit_done = run && tick && (sub_q == SW'(OSR - 1));

  always_comb begin
    pre_d = pre_q;
    sub_d = sub_q;
    if (!run) begin
      pre_d = '0;
      sub_d = '0;
    end else if (tick) begin
      pre_d = '0;
      sub_d = (sub_q == SW'(OSR - 1)) ? '0 : sub_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sub_q <= '0;
    end else begin
      pre_q <= pre_d;
      sub_q <= sub_d;
    end
  end

endmodule

// File: rtl/uft_cts.sv
module uft_cts (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_en,
  input  logic cts,
  input  logic block_req,
  output logic cts_wait
);
  logic cts_q, wait_q, wait_d, rise;

  assign rise     = cts && !cts_q;
  assign cts_wait = wait_q;

  always_comb begin
    wait_d = wait_q;
    if (!hs_en)         wait_d = 1'b0;
    else if (block_req) wait_d = 1'b1;
    else if (rise)      wait_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_q  <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      cts_q  <= cts;
      wait_q <= wait_d;
    end
  end

endmodule

// File: rtl/uart_fill_tx.sv
module uart_fill_tx #(
  parameter int               DATA_W    = 8,
  parameter int               DEPTH     = 4,
  parameter int               DIV_W     = 16,
  parameter logic [DATA_W-1:0] FILL_WORD = 8'hAA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             fill_en,
  input  logic             hs_en,
  input  logic             cts,
  input  logic             push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic             push_ready,
  output logic             txd,
  output logic             tx_active
);
  import uft_pkg::*;

  localparam int FRAME_BITS = DATA_W + 3;
  localparam int CW         = $clog2(FRAME_BITS);
  localparam int LW         = $clog2(DEPTH) + 1;

  uft_state_e          state_q, state_d;
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [CW-1:0]       cnt_q, cnt_d;

  logic              fifo_empty, fifo_full, pop, ld;
  logic [DATA_W-1:0] fifo_rdata;
  logic [LW-1:0]     fifo_level;
  logic              bit_done, boundary, pay_ok, block_req, cts_wait;

  uft_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_valid),
    .wdata (push_data),
    .pop   (pop),
    .rdata (fifo_rdata),
    .empty (fifo_empty),
    .full  (fifo_full),
    .level (fifo_level)
  );

  uft_baud #(.DIV_W(DIV_W), .OSR(OSR)) u_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state_q == ST_SHIFT),
    .div      (baud_div),
    .bit_done (bit_done)
  );

  uft_cts u_cts (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_en     (hs_en),
    .cts       (cts),
    .block_req (block_req),
    .cts_wait  (cts_wait)
  );

  assign boundary  = (state_q == ST_IDLE) ||
                     (bit_done && (cnt_q == CW'(FRAME_BITS - 1)));
  assign pay_ok    = !fifo_empty && (!hs_en || (cts && !cts_wait));
  assign block_req = boundary && hs_en && !fifo_empty && !cts;

  always_comb begin
    state_d = state_q;
    sr_d    = sr_q;
    cnt_d   = cnt_q;
    pop     = 1'b0;
    ld      = 1'b0;
    if (boundary) begin
      if (pay_ok) begin
        ld      = 1'b1;
        pop     = 1'b1;
        sr_d    = {1'b1, 1'b1, fifo_rdata, 1'b0};
        state_d = ST_SHIFT;
        cnt_d   = '0;
      end else if (fill_en) begin
        ld      = 1'b1;
        sr_d    = {1'b1, 1'b0, FILL_WORD, 1'b0};
        state_d = ST_SHIFT;
        cnt_d   = '0;
      end else begin
        state_d = ST_IDLE;
        sr_d    = '1;
        cnt_d   = '0;
      end
    end else if (bit_done) begin
      sr_d  = {1'b1, sr_q[FRAME_BITS-1:1]};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sr_q    <= '1;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      sr_q    <= sr_d;
      cnt_q   <= cnt_d;
    end
  end

  assign tx_active  = (state_q == ST_SHIFT);
  assign txd        = tx_active ? sr_q[0] : 1'b1;
  assign push_ready = !fifo_full;

endmodule

// File: rtl/uft_chk.sv
module uft_chk #(
  parameter int DEPTH = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    txd,
  input logic                    tx_active,
  input logic                    hs_en,
  input logic                    cts_wait,
  input logic                    pop,
  input logic                    ld,
  input logic                    bit_done,
  input logic                    fifo_empty,
  input logic [$clog2(DEPTH):0]  fifo_level
);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> txd);  // R6

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= ($clog2(DEPTH)+1)'(DEPTH));  // R8

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !ld && !bit_done) |=> $stable(txd));  // R5

  AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && cts_wait) |-> !pop);  // R7

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !fifo_empty);  // R3

endmodule

bind uart_fill_tx uft_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .txd        (txd),
  .tx_active  (tx_active),
  .hs_en      (hs_en),
  .cts_wait   (cts_wait),
  .pop        (pop),
  .ld         (ld),
  .bit_done   (bit_done),
  .fifo_empty (fifo_empty),
  .fifo_level (fifo_level)
);

// File: tb/sim_uart_fill_tx.sv
module sim_uart_fill_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int NVEC       = 6;
  // {divisor[7:0], byte[7:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'd0, 8'h55}, {8'd1, 8'hA3}, {8'd3, 8'h01},
    {8'd0, 8'hFF}, {8'd2, 8'h80}, {8'd0, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] baud_div;
  logic        fill_en, hs_en, cts, push_valid;
  logic [7:0]  push_data;
  logic        push_ready, txd, tx_active;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  uart_fill_tx u0 (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .fill_en(fill_en),
    .hs_en(hs_en), .cts(cts), .push_valid(push_valid), .push_data(push_data),
    .push_ready(push_ready), .txd(txd), .tx_active(tx_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    push_valid = 1'b1;
    push_data  = b;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  // Mid-bit sampler; word[7:0] data, word[8] marker
  task automatic rx_frame(input int div, input int limit, output logic [8:0] word,
                          output logic stop_ok, output int waited, output logic tmo);
    int len;
    len = 16 * (div + 1);
    waited = 0;
    tmo = 1'b0;
    word = '0;
    stop_ok = 1'b0;
    while (txd !== 1'b0) begin
      @(negedge clk);
      waited++;
      if (waited > limit) begin
        tmo = 1'b1;
        return;
      end
    end
    repeat (len/2) @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      repeat (len) @(negedge clk);
      word[i] = txd;
    end
    repeat (len) @(negedge clk);
    stop_ok = txd;
  endtask

  initial begin
    logic [8:0] w;
    logic       sok, tmo, hi;
    int         wt, lowcnt;
    bit         got;

    rst_n = 1'b0; baud_div = '0; fill_en = 1'b0; hs_en = 1'b0; cts = 1'b0;
    push_valid = 1'b0; push_data = '0;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(tx_active == 1'b0, "R1 tx_active", tx_active, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(push_ready == 1'b1, "R1 push_ready", push_ready, 1);

    // Table: payload frames at several divisors (R2, R3)
    for (int k = 0; k < NVEC; k++) begin
      baud_div = {8'd0, VEC[k][15:8]};
      push(VEC[k][7:0]);
      rx_frame(int'(VEC[k][15:8]), 200, w, sok, wt, tmo);
      chk(!tmo, "R2 frame start", tmo, 0);
      chk(w[7:0] == VEC[k][7:0], "R2 data bits", w[7:0], VEC[k][7:0]);
      chk(w[8] == 1'b1, "R3 marker", w[8], 1);
      chk(sok == 1'b1, "R2 stop bit", sok, 1);
      repeat (16 * (int'(VEC[k][15:8]) + 1)) @(negedge clk);
    end

    // R2: start bit length at divisor 2
    baud_div = 16'd2;
    push(8'h01);
    while (txd !== 1'b0) @(negedge clk);
    lowcnt = 0;
    while (txd === 1'b0) begin lowcnt++; @(negedge clk); end
    chk(lowcnt == 48, "R2 bit length", lowcnt, 48);
    while (tx_active) @(negedge clk);

    // R6: plain mode, empty queue stays silent
    baud_div = '0;
    hi = 1'b1;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (txd !== 1'b1 || tx_active !== 1'b0) hi = 1'b0;
    end
    chk(hi, "R6 idle line", hi, 1);

    // R9: cts ignored when handshake off
    cts = 1'b0;
    push(8'h81);
    rx_frame(0, 200, w, sok, wt, tmo);
    chk(!tmo && w == 9'h181, "R9 payload with cts low", w, 9'h181);
    while (tx_active) @(negedge clk);

    // R4: fill frames back to back
    fill_en = 1'b1;
    rx_frame(0, 200, w, sok, wt, tmo);
    chk(!tmo && w == 9'h0AA, "R4 fill frame", w, 9'h0AA);
    rx_frame(0, 200, w, sok, wt, tmo);
    chk(w == 9'h0AA, "R4 second fill", w, 9'h0AA);
    chk(wt <= 9, "R4 no gap", wt, 8);

    // R5: push during fill frame -> next frame
    fork
      rx_frame(0, 200, w, sok, wt, tmo);
      begin repeat (40) @(negedge clk); push(8'h3C); end
    join
    chk(w == 9'h0AA && sok, "R5 fill completes", w, 9'h0AA);
    rx_frame(0, 200, w, sok, wt, tmo);
    chk(w == 9'h13C, "R5 next is payload", w, 9'h13C);
    chk(wt <= 9, "R5 no gap", wt, 8);
    rx_frame(0, 200, w, sok, wt, tmo);
    chk(w == 9'h0AA, "R4 fill resumes", w, 9'h0AA);

    // R7: blocked in fill mode -> only fill frames
    hs_en = 1'b1; cts = 1'b0;
    push(8'h77);
    for (int f = 0; f < 3; f++) begin
      rx_frame(0, 200, w, sok, wt, tmo);
      chk(w == 9'h0AA, "R7 fill while blocked", w, 9'h0AA);
    end
    cts = 1'b1;
    got = 1'b0;
    for (int f = 0; f < 2 && !got; f++) begin
      rx_frame(0, 200, w, sok, wt, tmo);
      if (w[8]) got = 1'b1;
    end
    chk(got && w == 9'h177, "R7 payload after rise", w, 9'h177);
    fill_en = 1'b0;
    while (tx_active) @(negedge clk);

    // R7/R8: plain mode blocked, fill queue
    cts = 1'b0;
    @(negedge clk);
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    chk(push_ready == 1'b0, "R8 full", push_ready, 0);
    push(8'hEE);
    hi = 1'b1;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (txd !== 1'b1) hi = 1'b0;
    end
    chk(hi, "R7 silent while cts low", hi, 1);
    cts = 1'b1;
    for (int f = 0; f < 4; f++) begin
      rx_frame(0, 200, w, sok, wt, tmo);
      chk(!tmo && w == {1'b1, 4'(f + 1), 4'(f + 1)}, "R3 order after rise", w,
          {1'b1, 4'(f + 1), 4'(f + 1)});
    end
    rx_frame(0, 400, w, sok, wt, tmo);
    chk(tmo, "R8 push when full ignored", tmo, 1);
    chk(push_ready == 1'b1, "R8 ready after drain", push_ready, 1);

    finish_run();
  end

endmodule